// File: doc/BRIEF.md
# Saturating Hidden-Node Counter Bank with Serial Readout

This block holds one event counter per hidden node of a random-projection classifier. Each node receives pulses from its own oscillator, whose rate follows that node's summed input current. While the compute-enable input is high, every counter adds one for each oscillator pulse. Each counter stops at its own programmed ceiling, which turns the rate-to-count conversion into a saturating activation. A ceiling at the top of the counter range leaves the node linear across the whole range.

When compute-enable falls, the bank copies every count into a shadow register in the same cycle. It then presents the copied values one bit at a time on a serial output. The output advances by one bit for each readout step strobe. This frees a downstream processor to fetch the hidden-layer vector while the oscillators are idle.

The oscillator pulses arrive asynchronously. Each one passes through a two-flop synchronizer and a rising-edge detector before it reaches its counter. A control state machine has four states:
- IDLE: after reset; no frame has been latched.
- COUNT: counting.
- SHIFT: serial frame in progress.
- DONE: frame fully sent.

It has these transitions:
- Any state goes to COUNT on a rising compute-enable.
- COUNT goes to SHIFT on a falling compute-enable.
- SHIFT goes to DONE on the step that sends the last bit.

Top module: `hidden_count_bank`

## Requirements
- R1: After reset, `frame_valid` and `ser_data` are 0 and no readout is in progress.
- R2: While `compute_en` is high, each rising edge on `osc_pulse[i]` adds one to node i's counter, three clock edges after the pulse rises. Pulses while `compute_en` is low do not change any count.
- R3: Node i's count never exceeds its ceiling `stop_val[i*14 +: 14]`, and it never wraps. Pulses that arrive at the ceiling leave it unchanged. A ceiling of 0 keeps the count at 0. The ceilings are held steady while counting.
- R4: On the first clock edge that samples `compute_en` high after it was low, every counter clears to 0. Counts from an earlier run therefore do not carry over.
- R5: On the first edge that samples `compute_en` low after it was high, every count is copied to the shadow registers. Later oscillator pulses do not alter the frame being read out.
- R6: The frame is sent in a fixed order. The copy edge starts it with `frame_valid` high and the MSB of node 0 on `ser_data`. Each clock edge with `rd_step` high moves to the next bit: MSB first within a node, node 0 up to node 127. After 128×14 steps, `frame_valid` drops to 0.
- R7: `rd_step` has no effect outside a frame. Steps during counting or after the frame do not start, shift or shorten a frame. `ser_data` is 0 whenever `frame_valid` is 0.
- R8: A rising `compute_en` during a frame aborts it. `frame_valid` is 0 after that edge.
- R9: With a ceiling of 0x3FFF, the count follows the pulse count exactly up to 16383 and stays at 16383 beyond it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| compute_en | input | 1 | High during the counting phase |
| osc_pulse | input | 128 | One asynchronous oscillator pulse line per node |
| stop_val | input | 1792 | Per-node 14-bit ceilings; node i at bits i*14+13 down to i*14 |
| rd_step | input | 1 | Readout strobe; advances the serial output by one bit |
| ser_data | output | 1 | Current serial readout bit |
| frame_valid | output | 1 | High while a readout frame is presented |

## Verification
The embedded properties check on every cycle that:
- a counter never rises past its ceiling;
- a counter holds outside counting;
- a clear gives zero on the next edge;
- the shadow takes the pre-fall count;
- a rising enable ends any frame;
- the last step closes the frame.

Only the directed scenarios can show the following:
- the exact count for a given number of pulses;
- the bit order of the frame across all 128 nodes;
- immunity of the frame to pulses during readout;
- the effect of stray strobes;
- the full-range count up to 0x3FFF.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_SHIFT = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;
endpackage

// File: rtl/pulse_sync.sv
module pulse_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_out
);
    logic [2:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], async_in};
    end

    assign rise_out = stage[1] & ~stage[2];
endmodule

// File: rtl/node_counter.sv
module node_counter #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cnt_en,
    input  logic          latch,
    input  logic          pulse_edge,
    input  logic [CW-1:0] stop,
    output logic [CW-1:0] shadow
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                cnt <= '0;
        else if (clr)                              cnt <= '0;
        else if (cnt_en && pulse_edge && cnt < stop) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shadow <= '0;
        else if (latch) shadow <= cnt;
    end

    // R3: once at the ceiling, further pulses do not move the count
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en && pulse_edge && cnt >= stop) |=> $stable(cnt));
    // R2: the count holds while counting is off
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt_en) |=> $stable(cnt));
    // R4: a clear gives zero
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R5: the shadow takes the count present before the copy edge
    p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (shadow == $past(cnt)));
endmodule

// File: rtl/readout_fsm.sv
module readout_fsm
    import hcb_pkg::*;
#(
    parameter int NODES = 128,
    parameter int CW    = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_rise,
    input  logic                en_fall,
    input  logic                rd_step,
    input  logic [NODES*CW-1:0] shadow_flat,
    output logic                ser_data,
    output logic                frame_valid
);
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1;
    localparam int BW   = (CW > 1) ? $clog2(CW) : 1;
    localparam int TOTW = $clog2(NODES * CW);

    phase_t        state, state_nx;
    logic [NW-1:0] node_idx;
    logic [BW-1:0] bit_idx;
    logic          last_bit;
    logic          adv;
    logic [TOTW-1:0] sel;

    assign last_bit = (node_idx == NW'(NODES - 1)) && (bit_idx == '0);
    assign adv      = (state == PH_SHIFT) && rd_step && !en_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (en_rise) begin
            state_nx = PH_COUNT;
        end else begin
            unique case (state)
                PH_IDLE:  state_nx = PH_IDLE;
                PH_COUNT: if (en_fall) state_nx = PH_SHIFT;
                PH_SHIFT: if (rd_step && last_bit) state_nx = PH_DONE;
                PH_DONE:  state_nx = PH_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_idx <= '0;
            bit_idx  <= BW'(CW - 1);
        end else if (state == PH_COUNT && en_fall) begin
            node_idx <= '0;
            bit_idx  <= BW'(CW - 1);
        end else if (adv && !last_bit) begin
            if (bit_idx == '0) begin
                bit_idx  <= BW'(CW - 1);
                node_idx <= node_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    assign sel = TOTW'(node_idx) * TOTW'(CW) + TOTW'(bit_idx);

    always_comb begin
        frame_valid = (state == PH_SHIFT);
        ser_data    = frame_valid ? shadow_flat[sel] : 1'b0;
    end

    // R6: the final step closes the frame
    p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SHIFT && rd_step && last_bit && !en_rise) |=> !frame_valid);
    // R8: a rising enable ends any frame
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !frame_valid);
    // R7: outside a frame, steps leave the read position alone
    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_SHIFT && !en_fall) |=> ($stable(node_idx) && $stable(bit_idx)));
endmodule

// File: rtl/hidden_count_bank.sv
module hidden_count_bank #(
    parameter int NODES = 128,
    parameter int CW    = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                compute_en,
    input  logic [NODES-1:0]    osc_pulse,
    input  logic [NODES*CW-1:0] stop_val,
    input  logic                rd_step,
    output logic                ser_data,
    output logic                frame_valid
);
    logic                en_q;
    logic                en_rise, en_fall, cnt_en;
    logic [NODES-1:0]    edge_det;
    logic [NODES*CW-1:0] shadow_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= compute_en;
    end

    assign en_rise = compute_en & ~en_q;
    assign en_fall = ~compute_en & en_q;
    assign cnt_en  = compute_en & en_q;

    for (genvar g = 0; g < NODES; g++) begin : g_node
        pulse_sync i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (osc_pulse[g]),
            .rise_out (edge_det[g])
        );
        node_counter #(.CW(CW)) i_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (en_rise),
            .cnt_en     (cnt_en),
            .latch      (en_fall),
            .pulse_edge (edge_det[g]),
            .stop       (stop_val[g*CW +: CW]),
            .shadow     (shadow_flat[g*CW +: CW])
        );
    end

    readout_fsm #(.NODES(NODES), .CW(CW)) i_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .rd_step     (rd_step),
        .shadow_flat (shadow_flat),
        .ser_data    (ser_data),
        .frame_valid (frame_valid)
    );
endmodule

// File: tb/test_hidden_count_bank.sv
module test_hidden_count_bank;
    localparam int NODES = 128;
    localparam int CW    = 14;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = (1 << CW) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                compute_en = 1'b0;
    logic [NODES-1:0]    osc_pulse = '0;
    logic [NODES*CW-1:0] stop_val = '0;
    logic                rd_step = 1'b0;
    logic                ser_data;
    logic                frame_valid;

    int checks = 0;
    int errors = 0;
    int pulses_for [NODES];
    int expect_cnt [NODES];

    always #(CLK_PERIOD/2) clk = ~clk;

    hidden_count_bank #(.NODES(NODES), .CW(CW)) i_hidden_count_bank (
        .clk(clk), .rst_n(rst_n), .compute_en(compute_en), .osc_pulse(osc_pulse),
        .stop_val(stop_val), .rd_step(rd_step), .ser_data(ser_data),
        .frame_valid(frame_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_stop(input int n, input int v);
        stop_val[n*CW +: CW] = CW'(v);
    endtask

    // raise enable, send pulses per pulses_for[], drop enable
    task automatic run_count(input int maxp);
        @(negedge clk) compute_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < maxp; p++) begin
            for (int n = 0; n < NODES; n++) osc_pulse[n] = (pulses_for[n] > p);
            @(negedge clk) osc_pulse = '0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        compute_en = 1'b0;
        @(negedge clk);
    endtask

    // read one full frame and compare with expect_cnt[]
    task automatic read_frame(input bit noise, input string req);
        int got;
        bit fv_ok = 1'b1;
        rd_step = 1'b1;
        for (int n = 0; n < NODES; n++) begin
            got = 0;
            for (int b = 0; b < CW; b++) begin
                if (!frame_valid) fv_ok = 1'b0;
                got = (got << 1) | int'(ser_data);
                if (noise) osc_pulse = ~osc_pulse;
                @(negedge clk);
            end
            check(got == expect_cnt[n], req, got, expect_cnt[n]);
        end
        rd_step = 1'b0;
        osc_pulse = '0;
        check(fv_ok, "R6 frame_valid during frame", int'(fv_ok), 1);
        check(!frame_valid, "R6 frame_valid after last bit", int'(frame_valid), 0);
    endtask

    task automatic t_reset;
        check(!frame_valid, "R1 frame_valid after reset", int'(frame_valid), 0);
        check(!ser_data, "R1 ser_data after reset", int'(ser_data), 0);
    endtask

    task automatic t_basic_count;
        for (int n = 0; n < NODES; n++) begin
            set_stop(n, MAXC);
            pulses_for[n] = (n * 5) % 23;
            expect_cnt[n] = pulses_for[n];
        end
        run_count(23);
        read_frame(1'b0, "R2 R6 basic count");
    endtask

    task automatic t_saturate;
        for (int n = 0; n < NODES; n++) begin
            set_stop(n, n % 9);
            pulses_for[n] = 6 + (n % 4);
            expect_cnt[n] = (pulses_for[n] < n % 9) ? pulses_for[n] : n % 9;
        end
        run_count(10);
        read_frame(1'b0, "R3 ceiling");
    endtask

    task automatic t_clear_and_ignore;
        // R7: steps during counting; R4: fresh run clears; R5: noise during readout
        for (int n = 0; n < NODES; n++) begin
            set_stop(n, MAXC);
            pulses_for[n] = n % 3;
            expect_cnt[n] = n % 3;
        end
        @(negedge clk) compute_en = 1'b1;
        rd_step = 1'b1;
        repeat (3) @(negedge clk);
        check(!frame_valid, "R7 no frame during counting", int'(frame_valid), 0);
        rd_step = 1'b0;
        compute_en = 1'b0;
        @(negedge clk);
        run_count(3);
        read_frame(1'b1, "R4 R5 R7 clear and frozen frame");
        rd_step = 1'b1;
        osc_pulse = '1;
        repeat (3) @(negedge clk);
        check(!frame_valid, "R7 steps after frame", int'(frame_valid), 0);
        check(!ser_data, "R7 ser_data idle", int'(ser_data), 0);
        rd_step = 1'b0;
        osc_pulse = '0;
        repeat (4) @(negedge clk);
        check(!frame_valid, "R2 pulses with enable low", int'(frame_valid), 0);
    endtask

    task automatic t_abort;
        for (int n = 0; n < NODES; n++) pulses_for[n] = 1;
        run_count(1);
        check(frame_valid, "R6 frame starts on fall", int'(frame_valid), 1);
        rd_step = 1'b1;
        repeat (20) @(negedge clk);
        rd_step = 1'b0;
        compute_en = 1'b1;
        @(negedge clk);
        check(!frame_valid, "R8 abort on rising enable", int'(frame_valid), 0);
        compute_en = 1'b0;
        @(negedge clk);
        for (int n = 0; n < NODES; n++) expect_cnt[n] = 0;
        read_frame(1'b0, "R8 R4 frame after abort");
    endtask

    task automatic t_full_range;
        for (int n = 0; n < NODES; n++) begin
            set_stop(n, (n == 5) ? 100 : MAXC);
            pulses_for[n] = (n < 4) ? 300 : MAXC + 3;
            expect_cnt[n] = (n == 5) ? 100 : ((n < 4) ? 300 : MAXC);
        end
        run_count(MAXC + 3);
        read_frame(1'b0, "R9 R3 full range");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_count();
        t_saturate();
        t_clear_and_ignore();
        t_abort();
        t_full_range();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule